// File: doc/BRIEF.md
# Byte-Immediate Register Execution Unit

This block is the execute stage of a small 16-bit coprocessor. It owns eight 16-bit general registers and accepts one already-decoded operation per clock: an operation code, one register index, an 8-bit immediate field and a valid strobe, together with the address of the operation (`pc_in`). Each operation reads the named register, combines it with the immediate, and in the following cycle presents the register write, the updated condition flags, the address of the next operation, a semaphore grant and an interrupt request at its outputs. The register file is written on the same edge, so a back-to-back operation always sees the new value.

The operations are logical shifts by a 4-bit amount, byte loads, byte adds, a 16-bit subtract of a byte, a low-byte compare, a lock and an unlock of one of eight semaphores, a jump-and-link through a register, and a software interrupt to a channel held in a register. A 16-bit constant is loaded by a low-byte load and then a high-byte load. A 16-bit constant is added by a low-byte add and then a high-byte add. The carry out of the low step is kept in a link bit and folded into the high step, so the two steps give the full 16-bit sum.

Top module: `imm_exec_unit`

## Requirements
- R1: After reset every register holds zero and `wr_en`, `flags`, `pc_next`, `pc_redirect`, `sem_owned`, `sem_grant` and `irq_valid` are all zero.
- R2: Code 1 (shift left) and code 2 (shift right) shift the register logically by `op_imm[3:0]` places. C gets the last bit shifted out, or 0 for a zero amount. V is cleared.
- R3: Code 3 (load low) writes `{8'h00, imm}`. Code 4 (load high) writes `{imm, reg[7:0]}`. Neither changes the flags.
- R4: Code 5 (add low) adds imm to bits 7:0 and leaves bits 15:8 alone. C and the link bit get the carry out of bit 7, and V is the 8-bit signed overflow. Code 6 (add high) adds imm plus the link bit to bits 15:8. C is the carry out of bit 15, and V is the signed overflow of that high byte. Add low followed by add high on the same register gives the full 16-bit sum of the register and {high imm, low imm}.
- R5: Code 7 (subtract) writes reg − zero-extended imm over 16 bits. C is set when a borrow occurs. V is set when the register was negative and the result is not.
- R6: Code 8 (compare low) computes reg[7:0] − imm without writing any register. N is bit 7 of the byte difference, Z means the difference is zero, C is the borrow, and V is the 8-bit signed overflow.
- R7: Register 0 always reads as zero. An operation naming register 0 never asserts `wr_en`.
- R8: Code 9 (lock) on semaphore `op_imm[2:0]` is granted, and its `sem_owned` bit set, when `sem_held_other` for that semaphore is 0 or this unit already owns it. `sem_grant` pulses one cycle later when the lock is granted. Code 10 (unlock) clears the owned bit and has no effect on a semaphore that this unit does not own.
- R9: Code 11 (jump-and-link) sets `pc_next` to the register value, pulses `pc_redirect`, and writes `pc_in + 2` into that register.
- R10: Code 12 (software interrupt) pulses `irq_valid` for one cycle with `irq_chan` equal to bits 7:0 of the named register.
- R11: Every valid operation other than jump-and-link sets `pc_next` to `pc_in + 2`. Codes 0, 13, 14 and 15 change nothing else. `pc_next` holds while `op_valid` is low.
- R12: `flags` is {N, Z, V, C} in bits 3..0. Apart from code 8, N is bit 15 of the written result and Z means that result is zero. Only codes 1, 2, 5, 6, 7 and 8 update the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Decoded operation present this cycle |
| op_code | input | 4 | Operation code |
| op_reg | input | 3 | Register index (source and destination) |
| op_imm | input | 8 | Immediate field |
| pc_in | input | 16 | Address of the current operation |
| sem_held_other | input | 8 | Semaphores currently held by other masters |
| wr_en | output | 1 | Register write performed last cycle |
| wr_idx | output | 3 | Index of that write |
| wr_data | output | 16 | Value written |
| flags | output | 4 | Condition flags {N,Z,V,C} |
| pc_next | output | 16 | Address of the next operation |
| pc_redirect | output | 1 | Last operation was a jump |
| sem_owned | output | 8 | Semaphores owned by this unit |
| sem_grant | output | 1 | Last lock request was granted |
| irq_valid | output | 1 | Software interrupt request pulse |
| irq_chan | output | 8 | Channel of that request |

## Verification
The assertions check these rules on every cycle: a load low never leaves high bits set, a compare or a register-0 operation never writes, the jump link value and redirect, semaphore grants only on free or owned semaphores, interrupt pulses only after the interrupt code, cleared V after shifts, and a steady `pc_next` while idle. The arithmetic cannot be shown by a local property. The bench's scenarios and its reference model have to show the flag values of every operation, the two-step 16-bit add carrying through the link bit, the register contents that later operations read back, and the ownership history of the semaphore bank.

// File: rtl/imm_exec_pkg.sv
package imm_exec_pkg;
  localparam int DW    = 16;
  localparam int IMM_W = 8;
  localparam int SH_W  = 4;
  localparam int NREG  = 8;
  localparam int NSEM  = 8;
  localparam int OP_W  = 4;

  localparam logic [OP_W-1:0] OP_NOP  = 4'd0;
  localparam logic [OP_W-1:0] OP_LSL  = 4'd1;
  localparam logic [OP_W-1:0] OP_LSR  = 4'd2;
  localparam logic [OP_W-1:0] OP_LDL  = 4'd3;
  localparam logic [OP_W-1:0] OP_LDH  = 4'd4;
  localparam logic [OP_W-1:0] OP_ADDL = 4'd5;
  localparam logic [OP_W-1:0] OP_ADDH = 4'd6;
  localparam logic [OP_W-1:0] OP_SUBL = 4'd7;
  localparam logic [OP_W-1:0] OP_CMPL = 4'd8;
  localparam logic [OP_W-1:0] OP_LOCK = 4'd9;
  localparam logic [OP_W-1:0] OP_UNLK = 4'd10;
  localparam logic [OP_W-1:0] OP_JAL  = 4'd11;
  localparam logic [OP_W-1:0] OP_SWI  = 4'd12;

  // flag vector bit positions
  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_V = 1;
  localparam int FLG_C = 0;
endpackage

// File: rtl/imm_regfile.sv
module imm_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NREG)-1:0] rd_idx,
  output logic [DW-1:0]           rd_data,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] wr_idx,
  input  logic [DW-1:0]           wr_data
);
  localparam int AW = $clog2(NREG);

  logic [DW-1:0] entry [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign entry[i] = '0;
    end else begin : g_store
      logic [DW-1:0] q;
      logic          hit;
      assign hit = we && (wr_idx == AW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (hit) begin
          q <= wr_data;
        end
      end
      assign entry[i] = q;
    end
  end

  assign rd_data = entry[rd_idx];
endmodule

// File: rtl/imm_alu.sv
module imm_alu
  import imm_exec_pkg::*;
#(
  parameter int DW    = 16,
  parameter int IMM_W = 8,
  parameter int SH_W  = 4
) (
  input  logic [OP_W-1:0]  op,
  input  logic [DW-1:0]    rd_val,
  input  logic [IMM_W-1:0] imm,
  input  logic [DW-1:0]    pc,
  input  logic             link_in,
  output logic [DW-1:0]    res,
  output logic             wr_req,
  output logic             flag_upd,
  output logic [3:0]       flags_nxt,
  output logic             link_upd,
  output logic             link_nxt
);
  localparam int HB = DW - IMM_W;

  logic [DW:0]      shl_w;
  logic [DW:0]      shr_w;
  logic [IMM_W:0]   lo_sum;
  logic [IMM_W:0]   hi_sum;
  logic [DW:0]      sub_w;
  logic [IMM_W:0]   cmp_w;
  logic [SH_W-1:0]  amt;
  logic [IMM_W-1:0] lo_b;
  logic [IMM_W-1:0] hi_b;
  logic             n_f, z_f, v_f, c_f;

  assign amt   = imm[SH_W-1:0];
  assign lo_b  = rd_val[IMM_W-1:0];
  assign hi_b  = rd_val[DW-1:HB];
  assign shl_w = {1'b0, rd_val} << amt;
  assign shr_w = {rd_val, 1'b0} >> amt;
  assign lo_sum = {1'b0, lo_b} + {1'b0, imm};
  assign hi_sum = {1'b0, hi_b} + {1'b0, imm} + {{IMM_W{1'b0}}, link_in};
  assign sub_w  = {1'b0, rd_val} - {{(HB+1){1'b0}}, imm};
  assign cmp_w  = {1'b0, lo_b} - {1'b0, imm};

  always_comb begin
    res      = rd_val;
    wr_req   = 1'b0;
    flag_upd = 1'b0;
    link_upd = 1'b0;
    link_nxt = link_in;
    v_f      = 1'b0;
    c_f      = 1'b0;
    unique case (op)
      OP_LSL: begin
        res = shl_w[DW-1:0]; c_f = shl_w[DW];
        wr_req = 1'b1; flag_upd = 1'b1;
      end
      OP_LSR: begin
        res = shr_w[DW:1]; c_f = shr_w[0];
        wr_req = 1'b1; flag_upd = 1'b1;
      end
      OP_LDL: begin
        res = {{HB{1'b0}}, imm}; wr_req = 1'b1;
      end
      OP_LDH: begin
        res = {imm, rd_val[HB-1:0]}; wr_req = 1'b1;
      end
      OP_ADDL: begin
        res = {rd_val[DW-1:IMM_W], lo_sum[IMM_W-1:0]};
        c_f = lo_sum[IMM_W];
        v_f = (lo_b[IMM_W-1] == imm[IMM_W-1]) && (lo_sum[IMM_W-1] != lo_b[IMM_W-1]);
        link_upd = 1'b1; link_nxt = lo_sum[IMM_W];
        wr_req = 1'b1; flag_upd = 1'b1;
      end
      OP_ADDH: begin
        res = {hi_sum[IMM_W-1:0], rd_val[HB-1:0]};
        c_f = hi_sum[IMM_W];
        v_f = (hi_b[IMM_W-1] == imm[IMM_W-1]) && (hi_sum[IMM_W-1] != hi_b[IMM_W-1]);
        wr_req = 1'b1; flag_upd = 1'b1;
      end
      OP_SUBL: begin
        res = sub_w[DW-1:0];
        c_f = sub_w[DW];
        v_f = rd_val[DW-1] && !sub_w[DW-1];
        wr_req = 1'b1; flag_upd = 1'b1;
      end
      OP_CMPL: begin
        c_f = cmp_w[IMM_W];
        v_f = (lo_b[IMM_W-1] != imm[IMM_W-1]) && (cmp_w[IMM_W-1] != lo_b[IMM_W-1]);
        flag_upd = 1'b1;
      end
      OP_JAL: begin
        res = pc + DW'(2); wr_req = 1'b1;
      end
      default: begin
        res = rd_val;
      end
    endcase
  end

  always_comb begin
    if (op == OP_CMPL) begin
      n_f = cmp_w[IMM_W-1];
      z_f = (cmp_w[IMM_W-1:0] == '0);
    end else begin
      n_f = res[DW-1];
      z_f = (res == '0);
    end
  end

  assign flags_nxt = {n_f, z_f, v_f, c_f};
endmodule

// File: rtl/imm_sem_bank.sv
module imm_sem_bank #(
  parameter int NSEM = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lock_req,
  input  logic                    unlock_req,
  input  logic [$clog2(NSEM)-1:0] idx,
  input  logic [NSEM-1:0]         held_other,
  output logic [NSEM-1:0]         owned,
  output logic                    grant
);
  localparam int SW = $clog2(NSEM);

  logic [NSEM-1:0] owned_q, owned_d;
  logic            grant_q, grant_d;
  logic            may_take;

  assign may_take = owned_q[idx] || !held_other[idx];

  always_comb begin
    owned_d = owned_q;
    grant_d = 1'b0;
    for (int i = 0; i < NSEM; i++) begin
      if (idx == SW'(i)) begin
        if (lock_req && may_take) begin
          owned_d[i] = 1'b1;
        end else if (unlock_req && owned_q[i]) begin
          owned_d[i] = 1'b0;
        end
      end
    end
    if (lock_req && may_take) begin
      grant_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owned_q <= '0;
      grant_q <= 1'b0;
    end else begin
      owned_q <= owned_d;
      grant_q <= grant_d;
    end
  end

  assign owned = owned_q;
  assign grant = grant_q;
endmodule

// File: rtl/imm_exec_unit.sv
module imm_exec_unit
  import imm_exec_pkg::*;
#(
  parameter int P_DW    = imm_exec_pkg::DW,
  parameter int P_IMM_W = imm_exec_pkg::IMM_W,
  parameter int P_SH_W  = imm_exec_pkg::SH_W,
  parameter int P_NREG  = imm_exec_pkg::NREG,
  parameter int P_NSEM  = imm_exec_pkg::NSEM
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      op_valid,
  input  logic [OP_W-1:0]           op_code,
  input  logic [$clog2(P_NREG)-1:0] op_reg,
  input  logic [P_IMM_W-1:0]        op_imm,
  input  logic [P_DW-1:0]           pc_in,
  input  logic [P_NSEM-1:0]         sem_held_other,
  output logic                      wr_en,
  output logic [$clog2(P_NREG)-1:0] wr_idx,
  output logic [P_DW-1:0]           wr_data,
  output logic [3:0]                flags,
  output logic [P_DW-1:0]           pc_next,
  output logic                      pc_redirect,
  output logic [P_NSEM-1:0]         sem_owned,
  output logic                      sem_grant,
  output logic                      irq_valid,
  output logic [7:0]                irq_chan
);
  localparam int AW = $clog2(P_NREG);
  localparam int SW = $clog2(P_NSEM);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [P_DW-1:0] rd_val;
  logic [P_DW-1:0] alu_res;
  logic            alu_wr, alu_fu, alu_lu, alu_link;
  logic [3:0]      alu_flags;
  logic            link_q, link_d;
  logic            rf_we;
  logic            is_jal, is_swi, is_lock, is_unlk;

  imm_regfile #(.DW(P_DW), .NREG(P_NREG)) u_rf (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_idx  (op_reg),
    .rd_data (rd_val),
    .we      (rf_we),
    .wr_idx  (op_reg),
    .wr_data (alu_res)
  );

  imm_alu #(.DW(P_DW), .IMM_W(P_IMM_W), .SH_W(P_SH_W)) u_alu (
    .op        (op_code),
    .rd_val    (rd_val),
    .imm       (op_imm),
    .pc        (pc_in),
    .link_in   (link_q),
    .res       (alu_res),
    .wr_req    (alu_wr),
    .flag_upd  (alu_fu),
    .flags_nxt (alu_flags),
    .link_upd  (alu_lu),
    .link_nxt  (alu_link)
  );

  assign is_jal  = op_valid && (op_code == OP_JAL);
  assign is_swi  = op_valid && (op_code == OP_SWI);
  assign is_lock = op_valid && (op_code == OP_LOCK);
  assign is_unlk = op_valid && (op_code == OP_UNLK);
  assign rf_we   = op_valid && alu_wr && (op_reg != '0);

  imm_sem_bank #(.NSEM(P_NSEM)) u_sem (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .lock_req   (is_lock),
    .unlock_req (is_unlk),
    .idx        (op_imm[SW-1:0]),
    .held_other (sem_held_other),
    .owned      (sem_owned),
    .grant      (sem_grant)
  );

  // output and state registers
  logic            wr_en_q, wr_en_d;
  logic [AW-1:0]   wr_idx_q;
  logic [P_DW-1:0] wr_data_q;
  logic [3:0]      flags_q, flags_d;
  logic            flags_ce;
  logic [P_DW-1:0] pc_q, pc_d;
  logic            pc_ce;
  logic            redir_q, redir_d;
  logic            irq_q, irq_d;
  logic [7:0]      chan_q;

  always_comb begin
    wr_en_d  = rf_we;
    flags_ce = op_valid && alu_fu;
    flags_d  = alu_flags;
    link_d   = (op_valid && alu_lu) ? alu_link : link_q;
    pc_ce    = op_valid;
    pc_d     = is_jal ? rd_val : (pc_in + P_DW'(2));
    redir_d  = is_jal;
    irq_d    = is_swi;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
      flags_q   <= '0;
      link_q    <= 1'b0;
      pc_q      <= '0;
      redir_q   <= 1'b0;
      irq_q     <= 1'b0;
      chan_q    <= '0;
    end else begin
      wr_en_q <= wr_en_d;
      redir_q <= redir_d;
      irq_q   <= irq_d;
      link_q  <= link_d;
      if (wr_en_d) begin
        wr_idx_q  <= op_reg;
        wr_data_q <= alu_res;
      end
      if (flags_ce) begin
        flags_q <= flags_d;
      end
      if (pc_ce) begin
        pc_q <= pc_d;
      end
      if (is_swi) begin
        chan_q <= rd_val[7:0];
      end
    end
  end

  assign wr_en       = wr_en_q;
  assign wr_idx      = wr_idx_q;
  assign wr_data     = wr_data_q;
  assign flags       = flags_q;
  assign pc_next     = pc_q;
  assign pc_redirect = redir_q;
  assign irq_valid   = irq_q;
  assign irq_chan    = chan_q;
endmodule

// File: rtl/imm_exec_chk.sv
module imm_exec_chk
  import imm_exec_pkg::*;
(
  input logic        clk,
  input logic        rst_ok,
  input logic        op_valid,
  input logic [3:0]  op_code,
  input logic [2:0]  op_reg,
  input logic [7:0]  op_imm,
  input logic [15:0] pc_in,
  input logic [7:0]  sem_held_other,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [3:0]  flags,
  input logic [15:0] pc_next,
  input logic        pc_redirect,
  input logic [7:0]  sem_owned,
  input logic        sem_grant,
  input logic        irq_valid
);
  AST_SHIFT_CLEARS_V: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && (op_code == OP_LSL || op_code == OP_LSR)) |=> !flags[FLG_V]); // R2

  AST_LOAD_LOW_ZERO_HIGH: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && op_code == OP_LDL && op_reg != 3'd0)
      |=> (wr_en && wr_data == {8'h00, $past(op_imm)})); // R3

  AST_COMPARE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && op_code == OP_CMPL) |=> !wr_en); // R6

  AST_ZERO_REG_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && op_reg == 3'd0) |=> !wr_en); // R7

  AST_GRANT_MEANS_OWNED: assert property (@(posedge clk) disable iff (!rst_ok)
    sem_grant |-> sem_owned[$past(op_imm[2:0])]); // R8

  AST_LOCK_BLOCKED: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && op_code == OP_LOCK && sem_held_other[op_imm[2:0]] && !sem_owned[op_imm[2:0]])
      |=> !sem_grant); // R8

  AST_JUMP_LINK: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && op_code == OP_JAL && op_reg != 3'd0)
      |=> (wr_en && pc_redirect && wr_data == $past(pc_in) + 16'd2)); // R9

  AST_IRQ_ONLY_AFTER_SWI: assert property (@(posedge clk) disable iff (!rst_ok)
    irq_valid |-> $past(op_valid && op_code == OP_SWI)); // R10

  AST_PC_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_ok)
    !op_valid |=> $stable(pc_next)); // R11
endmodule

bind imm_exec_unit imm_exec_chk u_chk (
  .clk            (clk),
  .rst_ok         (rst_sync_n),
  .op_valid       (op_valid),
  .op_code        (op_code),
  .op_reg         (op_reg),
  .op_imm         (op_imm),
  .pc_in          (pc_in),
  .sem_held_other (sem_held_other),
  .wr_en          (wr_en),
  .wr_data        (wr_data),
  .flags          (flags),
  .pc_next        (pc_next),
  .pc_redirect    (pc_redirect),
  .sem_owned      (sem_owned),
  .sem_grant      (sem_grant),
  .irq_valid      (irq_valid)
);

// File: tb/tb_imm_exec_unit.sv
module tb_imm_exec_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [2:0]  op_reg;
  logic [7:0]  op_imm;
  logic [15:0] pc_in;
  logic [7:0]  sem_held_other;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [15:0] wr_data;
  logic [3:0]  flags;
  logic [15:0] pc_next;
  logic        pc_redirect;
  logic [7:0]  sem_owned;
  logic        sem_grant;
  logic        irq_valid;
  logic [7:0]  irq_chan;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  imm_exec_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_reg(op_reg), .op_imm(op_imm), .pc_in(pc_in),
    .sem_held_other(sem_held_other), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .flags(flags), .pc_next(pc_next),
    .pc_redirect(pc_redirect), .sem_owned(sem_owned), .sem_grant(sem_grant),
    .irq_valid(irq_valid), .irq_chan(irq_chan)
  );

  // reference model state
  int regs [8];
  int m_flags, m_link, m_pc, m_owned;
  int m_chan;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int op, input int r);
    if (r == 0 && (op inside {1,2,3,4,5,6,7,11})) return "R7";
    case (op)
      1, 2:  return "R2";
      3, 4:  return "R3";
      5, 6:  return "R4";
      7:     return "R5";
      8:     return "R6";
      9, 10: return "R8";
      11:    return "R9";
      12:    return "R10";
      default: return "R11";
    endcase
  endfunction

  // one cycle: drive at negedge, predict, compare at the next negedge
  task automatic step(input bit v, input int op, input int r, input int imm,
                      input int pc, input int other);
    int rv, res, c, vv, s, a, h, l, d, idx;
    bit we, fu, irq, redir, grant;
    string tg;
    op_valid = v; op_code = 4'(op); op_reg = 3'(r); op_imm = 8'(imm);
    pc_in = 16'(pc); sem_held_other = 8'(other);
    rv = (r == 0) ? 0 : regs[r];
    res = rv; we = 0; fu = 0; irq = 0; redir = 0; grant = 0; c = 0; vv = 0;
    tg = tag_of(op, r);
    if (v) begin
      case (op)
        1: begin a = imm & 15; s = rv << a; res = s & 16'hFFFF; c = (s >> 16) & 1; we = 1; fu = 1; end
        2: begin a = imm & 15; res = rv >> a; c = (a == 0) ? 0 : (rv >> (a - 1)) & 1; we = 1; fu = 1; end
        3: begin res = imm; we = 1; end
        4: begin res = (imm << 8) | (rv & 255); we = 1; end
        5: begin
          s = (rv & 255) + imm; res = (rv & 16'hFF00) | (s & 255); c = s >> 8;
          vv = (((rv >> 7) & 1) == ((imm >> 7) & 1)) && (((s >> 7) & 1) != ((rv >> 7) & 1));
          m_link = c; we = 1; fu = 1;
        end
        6: begin
          h = (rv >> 8) & 255; s = h + imm + m_link; res = ((s & 255) << 8) | (rv & 255);
          c = s >> 8; vv = (((h >> 7) & 1) == ((imm >> 7) & 1)) && (((s >> 7) & 1) != ((h >> 7) & 1));
          we = 1; fu = 1;
        end
        7: begin
          res = (rv - imm) & 16'hFFFF; c = (rv < imm);
          vv = ((rv >> 15) & 1) && !((res >> 15) & 1); we = 1; fu = 1;
        end
        8: begin
          l = rv & 255; d = (l - imm) & 255; c = (l < imm);
          vv = (((l >> 7) & 1) != ((imm >> 7) & 1)) && (((d >> 7) & 1) != ((l >> 7) & 1));
          m_flags = (((d >> 7) & 1) << 3) | ((d == 0) << 2) | (vv << 1) | c;
        end
        9: begin
          idx = imm & 7;
          if (((m_owned >> idx) & 1) || !((other >> idx) & 1)) begin
            grant = 1; m_owned = m_owned | (1 << idx);
          end
        end
        10: begin idx = imm & 7; m_owned = m_owned & ~(1 << idx); end
        11: begin res = (pc + 2) & 16'hFFFF; we = 1; redir = 1; end
        12: begin irq = 1; m_chan = rv & 255; end
        default: ;
      endcase
      if (fu) m_flags = (((res >> 15) & 1) << 3) | ((res == 0) << 2) | (vv << 1) | c;
      m_pc = (op == 11) ? rv : ((pc + 2) & 16'hFFFF);
      if (r == 0) we = 0;
      if (we) regs[r] = res;
    end
    @(negedge clk);
    chk(wr_en == we, tg, "wr_en", wr_en, we);
    if (we) begin
      chk(wr_idx == 3'(r), tg, "wr_idx", wr_idx, r);
      chk(wr_data == 16'(res), tg, "wr_data", wr_data, res);
    end
    chk(flags == 4'(m_flags), "R12", "flags", flags, m_flags);
    chk(pc_next == 16'(m_pc), (op == 11 && v) ? "R9" : "R11", "pc_next", pc_next, m_pc);
    chk(pc_redirect == redir, tg, "pc_redirect", pc_redirect, redir);
    chk(sem_owned == 8'(m_owned), "R8", "sem_owned", sem_owned, m_owned);
    chk(sem_grant == grant, "R8", "sem_grant", sem_grant, grant);
    chk(irq_valid == irq, "R10", "irq_valid", irq_valid, irq);
    if (irq) chk(irq_chan == 8'(m_chan), "R10", "irq_chan", irq_chan, m_chan);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = 0;
    m_flags = 0; m_link = 0; m_pc = 0; m_owned = 0; m_chan = 0;
    rst_n = 1'b0; op_valid = 0; op_code = 0; op_reg = 0; op_imm = 0;
    pc_in = 0; sem_held_other = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(wr_en == 0, "R1", "wr_en", wr_en, 0);
    chk(flags == 0, "R1", "flags", flags, 0);
    chk(pc_next == 0, "R1", "pc_next", pc_next, 0);
    chk(pc_redirect == 0, "R1", "pc_redirect", pc_redirect, 0);
    chk(sem_owned == 0, "R1", "sem_owned", sem_owned, 0);
    chk(sem_grant == 0, "R1", "sem_grant", sem_grant, 0);
    chk(irq_valid == 0, "R1", "irq_valid", irq_valid, 0);
    // R1: registers read back as zero through a subtract of zero
    step(1, 7, 5, 0, 16'h0100, 0);
    chk(wr_data == 0, "R1", "reg5 after reset", wr_data, 0);

    // R3 byte loads build 0x80F0, R4 two-step add of 0x1234
    step(1, 3, 4, 8'hF0, 16'h0102, 0);
    step(1, 4, 4, 8'h80, 16'h0104, 0);
    step(1, 5, 4, 8'h34, 16'h0106, 0);
    step(1, 6, 4, 8'h12, 16'h0108, 0);
    chk(wr_data == 16'h9324, "R4", "16-bit sum", wr_data, 16'h9324);

    // R2 shifts, including zero amount and a bit shifted out
    step(1, 1, 4, 1, 16'h010A, 0);
    step(1, 2, 4, 3, 16'h010C, 0);
    step(1, 1, 4, 0, 16'h010E, 0);
    step(1, 2, 4, 15, 16'h0110, 0);

    // R5 subtract with borrow, R6 compare leaves register alone
    step(1, 7, 2, 1, 16'h0112, 0);
    step(1, 8, 2, 8'hFF, 16'h0114, 0);
    step(1, 8, 2, 8'h10, 16'h0116, 0);
    step(1, 7, 2, 0, 16'h0118, 0);

    // R7 register 0
    step(1, 3, 0, 8'h55, 16'h011A, 0);
    step(1, 11, 0, 0, 16'h011C, 0);

    // R8 semaphores
    step(1, 9, 0, 3, 16'h0200, 8'h00);
    step(1, 9, 0, 5, 16'h0202, 8'h20);
    step(1, 9, 0, 3, 16'h0204, 8'h08);
    step(1, 10, 0, 5, 16'h0206, 8'h20);
    step(1, 10, 0, 3, 16'h0208, 0);

    // R9 jump-and-link, R10 interrupt
    step(1, 3, 1, 8'h40, 16'h0300, 0);
    step(1, 11, 1, 0, 16'h0302, 0);
    step(1, 3, 2, 8'h9A, 16'h0040, 0);
    step(1, 12, 2, 0, 16'h0042, 0);

    // R11 idle and undefined codes
    idle(); idle();
    step(1, 13, 3, 8'hAA, 16'h0500, 0);
    step(1, 0, 3, 8'hAA, 16'h0502, 0);

    for (int i = 0; i < 600; i++) begin
      step(($urandom % 5) != 0, $urandom % 16, $urandom % 8, $urandom % 256,
           $urandom & 16'hFFFE, $urandom % 256);
    end

    summary();
    $finish;
  end
endmodule